// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is a bus master for a small serial EEPROM of 64 sixteen-bit words that is reached over chip select, a serial clock, a serial data line out and a serial data line back. A requester on the parallel side offers one command at a time with a valid/ready handshake. The command can be a word read, a word write, a word erase, an erase of the whole array, a write of one value to the whole array, or the enable or disable of programming. The controller turns the command into a serial frame. It clocks the frame out at a rate set by a divider parameter and collects any returned data. It then reports completion with a one-cycle done pulse.

For reads, the controller drops the zero bit that the memory sends ahead of the data and returns the 16 bits that follow. For the four programming commands, the controller lowers chip select for a guard interval. It then raises chip select again and watches the returned line until the memory shows ready. A poll timer stops a programming cycle that never finishes and flags it as an error. A per-request option makes the controller send a programming enable frame before a programming command.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, chip select, serial clock and serial data out are low, ready is high and done and error are low.
- R2: Every frame is sent MSB first and is made of a 1, a 2-bit opcode and a 6-bit address. The opcode is 10 for read, 01 for write and 11 for erase. The command code requests this frame (req_cmd_i 0 read, 1 write, 2 erase). Opcode 00 marks a special command, and the top two address bits then select it: 11 enable (code 5), 10 erase-all (code 3), 01 write-all (code 4), 00 disable (code 6 and code 7). For special commands the lower four address bits carry the requested address. Write and write-all append the 16 data bits MSB first.
- R3: A read sends 25 clock pulses and samples the returned line on each falling clock edge. The first returned bit, a dummy, is discarded and the next 16 bits form rdata_o, with the first received bit as the MSB.
- R4: The serial clock toggles only while chip select is high. Each clock level inside a frame lasts HALF_DIV cycles. Serial data out changes only while the clock is low.
- R5: Chip select stays low for at least CS_GAP cycles after every frame, poll phase or reset before it rises again.
- R6: After a write, erase, erase-all or write-all frame and the guard gap, chip select is raised with no clock pulses until the returned line reads 1. Chip select then drops and done pulses with error low.
- R7: If the returned line stays 0 for POLL_LIMIT cycles of polling, chip select drops, and done pulses with err_o high in the same cycle.
- R8: With req_auto_en_i set on a programming command, an enable frame is sent before the command frame. On read, enable or disable requests the bit has no effect and a single frame is sent.
- R9: Ready is high only while the controller is idle. A request is taken on a cycle with valid and ready both high. Each taken request yields exactly one done pulse of one cycle.
- R10: Serial data out is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_cmd_i | input | 3 | Command code (see R2) |
| req_addr_i | input | AW (6) | Word address |
| req_data_i | input | DW (16) | Data for write and write-all |
| req_auto_en_i | input | 1 | Send an enable frame first for programming commands |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll timeout, valid with done_o |
| rdata_o | output | DW (16) | Word from the last read |
| cs_o | output | 1 | Serial chip select |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data toward the memory |
| do_i | input | 1 | Serial data from the memory |

## Verification
A wrong bit counter or a wrong shift register would appear at the pins within one frame. It would show as a frame of the wrong length, a wrong header seen by the memory model, or a read word shifted by one bit because the dummy was kept. A stuck state in the gap or poll path would appear as chip select rising too early, no poll phase after a write, or a missing done pulse. This becomes visible within a guard interval or within a poll window of POLL_LIMIT cycles. A memory model in the bench decodes every frame, times every clock level and chip select gap, and records the frames of each request for comparison.

// File: rtl/mwh_pkg.sv
// Shared types for the serial EEPROM host: request codes and controller states.
// Assumes the parallel side encodes commands exactly as cmd_e below.
package mwh_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_ERAL  = 3'd3,
        CMD_WRAL  = 3'd4,
        CMD_EWEN  = 3'd5,
        CMD_EWDS  = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SHIFT,
        S_GAP,
        S_POLL,
        S_TAIL,
        S_DONE
    } st_e;

    // True for the commands that start a self-timed programming cycle.
    function automatic logic is_prog(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) ||
               (c == CMD_ERAL)  || (c == CMD_WRAL);
    endfunction

endpackage

// File: rtl/mwh_sk_div.sv
// Half-period divider for the serial clock: pulses tick_o once every HALF_DIV
// cycles while en_i is high and restarts its count whenever en_i drops.
// Assumes HALF_DIV >= 4.
module mwh_sk_div #(
    parameter int HALF_DIV = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int DCW = $clog2(HALF_DIV);

    logic [DCW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == DCW'(HALF_DIV - 1));

    // Count cycles of the current clock half, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: half periods never collapse into back-to-back ticks.
    p_tick_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/mwh_wait_cnt.sv
// Loadable down-counter shared by the chip-select gap and the poll timeout.
// zero_o is high once the loaded count has run out; it holds at zero.
module mwh_wait_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    assign zero_o = (cnt_q == '0);

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (!zero_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/mwh_frame_gen.sv
// Builds the left-aligned serial frame for one command: start bit, opcode,
// address and, for write and write-all, the data word. Also returns the
// number of clock pulses the frame needs (reads include dummy plus data).
module mwh_frame_gen
    import mwh_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    localparam int FW = 3 + AW + DW,
    localparam int CW = $clog2(FW + 1)
) (
    input  cmd_e          cmd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic [FW-1:0] frame_o,
    output logic [CW-1:0] nbits_o
);
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          long_f;

    // Select opcode, address field and payload for the requested command.
    always_comb begin
        op     = 2'b00;
        a      = addr_i;
        d      = '0;
        long_f = 1'b0;
        case (cmd_i)
            CMD_READ:  begin op = 2'b10; long_f = 1'b1; end
            CMD_WRITE: begin op = 2'b01; d = data_i; long_f = 1'b1; end
            CMD_ERASE: op = 2'b11;
            CMD_ERAL:  a = {2'b10, addr_i[AW-3:0]};
            CMD_WRAL:  begin a = {2'b01, addr_i[AW-3:0]}; d = data_i; long_f = 1'b1; end
            CMD_EWEN:  a = {2'b11, addr_i[AW-3:0]};
            default:   a = {2'b00, addr_i[AW-3:0]};
        endcase
        frame_o = {1'b1, op, a, d};
        nbits_o = long_f ? CW'(FW) : CW'(3 + AW);
    end

endmodule

// File: rtl/mw_eeprom_host.sv
// Host controller for a three-wire serial EEPROM. Takes one request at a
// time, shifts its frame out, reads back data, guards chip-select low time,
// polls for end of programming with a timeout and pulses done.
// Assumes one memory on the bus, HALF_DIV >= 4 (do_i passes a two-flop
// synchroniser) and CS_GAP, POLL_LIMIT >= 2.
module mw_eeprom_host
    import mwh_pkg::*;
#(
    parameter int AW         = 6,
    parameter int DW         = 16,
    parameter int HALF_DIV   = 63,
    parameter int CS_GAP     = 63,
    parameter int POLL_LIMIT = 2500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic [2:0]    req_cmd_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_data_i,
    input  logic          req_auto_en_i,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] rdata_o,
    output logic          cs_o,
    output logic          sk_o,
    output logic          di_o,
    input  logic          do_i
);
    localparam int FW   = 3 + AW + DW;
    localparam int CW   = $clog2(FW + 1);
    localparam int WMAX = (CS_GAP > POLL_LIMIT) ? CS_GAP : POLL_LIMIT;
    localparam int WCW  = $clog2(WMAX + 1);
    localparam int LRW  = $clog2(CS_GAP + 1);

    st_e           state_q;
    cmd_e          cmd_q;
    cmd_e          cur_cmd;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          pre_en_q;
    logic          tmo_q;
    logic [FW-1:0] tx_q;
    logic [DW-1:0] rx_q;
    logic [CW-1:0] left_q;
    logic          sk_q, cs_q, done_q, err_q;
    logic [DW-1:0] rdata_q;
    logic          do_m, do_s;
    logic [FW-1:0] frame;
    logic [CW-1:0] nbits;
    logic          tick;
    logic          w_load, w_zero;
    logic [WCW-1:0] w_val;
    logic          last_fall;

    assign cur_cmd     = pre_en_q ? CMD_EWEN : cmd_q;
    assign req_ready_o = (state_q == S_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign rdata_o     = rdata_q;
    assign cs_o        = cs_q;
    assign sk_o        = sk_q;
    assign di_o        = cs_q & tx_q[FW-1];
    assign last_fall   = (state_q == S_SHIFT) && tick && sk_q && (left_q == CW'(1));

    mwh_frame_gen #(.AW(AW), .DW(DW)) u_frame (
        .cmd_i   (cur_cmd),
        .addr_i  (addr_q),
        .data_i  (data_q),
        .frame_o (frame),
        .nbits_o (nbits)
    );

    mwh_sk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q == S_SHIFT),
        .tick_o (tick)
    );

    mwh_wait_cnt #(.W(WCW)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (w_load),
        .val_i  (w_val),
        .zero_o (w_zero)
    );

    // Bring the memory's data line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            do_m <= 1'b0;
            do_s <= 1'b0;
        end else begin
            do_m <= do_i;
            do_s <= do_m;
        end
    end

    // Choose when and with what the shared wait counter is loaded.
    always_comb begin
        w_load = 1'b0;
        w_val  = '0;
        if (last_fall) begin
            w_load = 1'b1;
            w_val  = WCW'(CS_GAP - 1);
        end else if (state_q == S_GAP && w_zero && !pre_en_q && is_prog(cmd_q)) begin
            w_load = 1'b1;
            w_val  = WCW'(POLL_LIMIT - 1);
        end else if (state_q == S_POLL && (do_s || w_zero)) begin
            w_load = 1'b1;
            w_val  = WCW'(CS_GAP - 1);
        end
    end

    // Main sequencer: accept, shift, gap, poll, tail gap, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            cmd_q    <= CMD_READ;
            addr_q   <= '0;
            data_q   <= '0;
            pre_en_q <= 1'b0;
            tmo_q    <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
            left_q   <= '0;
            sk_q     <= 1'b0;
            cs_q     <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                S_IDLE: if (req_valid_i) begin
                    cmd_q    <= cmd_e'(req_cmd_i);
                    addr_q   <= req_addr_i;
                    data_q   <= req_data_i;
                    pre_en_q <= req_auto_en_i && is_prog(cmd_e'(req_cmd_i));
                    tmo_q    <= 1'b0;
                    state_q  <= S_LOAD;
                end
                S_LOAD: begin
                    tx_q    <= frame;
                    left_q  <= nbits;
                    cs_q    <= 1'b1;
                    state_q <= S_SHIFT;
                end
                S_SHIFT: if (tick) begin
                    if (!sk_q) begin
                        sk_q <= 1'b1;
                    end else begin
                        sk_q   <= 1'b0;
                        rx_q   <= {rx_q[DW-2:0], do_s};
                        tx_q   <= {tx_q[FW-2:0], 1'b0};
                        left_q <= left_q - 1'b1;
                        if (left_q == CW'(1)) begin
                            cs_q    <= 1'b0;
                            state_q <= S_GAP;
                        end
                    end
                end
                S_GAP: if (w_zero) begin
                    if (pre_en_q) begin
                        pre_en_q <= 1'b0;
                        state_q  <= S_LOAD;
                    end else if (is_prog(cmd_q)) begin
                        cs_q    <= 1'b1;
                        state_q <= S_POLL;
                    end else begin
                        state_q <= S_DONE;
                    end
                end
                S_POLL: if (do_s || w_zero) begin
                    tmo_q   <= !do_s;
                    cs_q    <= 1'b0;
                    state_q <= S_TAIL;
                end
                S_TAIL: if (w_zero) state_q <= S_DONE;
                default: begin
                    done_q  <= 1'b1;
                    err_q   <= tmo_q;
                    if (cmd_q == CMD_READ) rdata_q <= rx_q;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    // Checker state: cycles chip select has been low, saturating at CS_GAP.
    logic [LRW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)            low_run <= LRW'(CS_GAP);
        else if (cs_q)         low_run <= '0;
        else if (low_run != LRW'(CS_GAP)) low_run <= low_run + 1'b1;
    end

    // R4: no clock pulse outside a selected frame.
    p_sk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);
    // R4: data toward the memory holds while the clock is high.
    p_di_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o && $past(sk_o)) |-> $stable(di_o));
    // R5: chip select only rises after a full guard gap.
    p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> (low_run >= LRW'(CS_GAP)));
    // R7: the error flag appears only alongside done.
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
    // R9: done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: never ready while the bus is in use.
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> !req_ready_o);
    // R10: data line quiet while deselected.
    p_di_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_o |-> !di_o);

endmodule

// File: tb/mw_eeprom_host_test.sv
// Directed bench with a behavioural serial memory model sampled on the
// falling system clock edge.
module mw_eeprom_host_test;
    localparam int HALF  = 4;
    localparam int GAP   = 6;
    localparam int PLIM  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_auto = 1'b0;
    logic [2:0] req_cmd = '0;
    logic [5:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic req_ready, done_o, err_o, cs, sk, di;
    logic [15:0] rdata;
    logic do_r = 1'b0;

    always #2 clk = ~clk;

    mw_eeprom_host #(.AW(6), .DW(16), .HALF_DIV(HALF), .CS_GAP(GAP), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_cmd_i(req_cmd), .req_addr_i(req_addr), .req_data_i(req_data),
        .req_auto_en_i(req_auto), .done_o(done_o), .err_o(err_o), .rdata_o(rdata),
        .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(do_r)
    );

    int n_chk = 0, n_err = 0;
    logic [15:0] mem [0:63];
    int bitcnt, low_cnt, run, busy, busy_len, rd_idx, nfrm, poll_cnt;
    int gap_viol = 0, sk_viol = 0, di_viol = 0;
    logic [24:0] sh;
    logic [5:0] raddr;
    logic reading, dout, wen, cs_p, sk_p;
    logic [8:0] log_hdr [0:3];
    logic [15:0] log_dat [0:3];
    int log_len [0:3];
    logic got_err;
    logic [15:0] got_rd;
    int got_cyc;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model: decode a completed frame and apply it to the array.
    task automatic finish_frame();
        logic [8:0] hd;
        logic [15:0] fd;
        int n;
        n  = bitcnt;
        hd = (n == 25) ? sh[24:16] : sh[8:0];
        fd = sh[15:0];
        if (nfrm < 4) begin
            log_hdr[nfrm] = hd; log_dat[nfrm] = fd; log_len[nfrm] = n;
        end
        nfrm++;
        case (hd[7:6])
            2'b01: if (n == 25 && wen) begin mem[hd[5:0]] = fd; busy = busy_len; end
            2'b11: if (n == 9 && wen) begin mem[hd[5:0]] = 16'hFFFF; busy = busy_len; end
            2'b00: case (hd[5:4])
                2'b11: wen = 1'b1;
                2'b00: wen = 1'b0;
                2'b10: if (n == 9 && wen) begin
                    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                    busy = busy_len;
                end
                default: if (n == 25 && wen) begin
                    for (int i = 0; i < 64; i++) mem[i] = fd;
                    busy = busy_len;
                end
            endcase
            default: ;
        endcase
    endtask

    // Memory model and pin monitors.
    always @(negedge clk) begin
        if (!rst_n) begin
            cs_p = 0; sk_p = 0; bitcnt = 0; low_cnt = 100; run = 0; busy = 0;
            reading = 0; wen = 0; do_r = 0; dout = 0; sh = '0;
        end else begin
            if (busy > 0) busy--;
            if (!cs && di) di_viol++;
            if (sk != sk_p) begin
                if (!sk) begin if (run != HALF) sk_viol++; end
                else if (bitcnt > 0 && run != HALF) sk_viol++;
                run = 1;
            end else run++;
            if (cs && !cs_p) begin
                if (low_cnt < GAP) gap_viol++;
                bitcnt = 0; sh = '0; reading = 0;
            end
            if (cs && sk && !sk_p) begin
                sh = {sh[23:0], di};
                bitcnt++;
                if (reading) begin
                    dout = (rd_idx >= 0) ? mem[raddr][rd_idx] : 1'b0;
                    rd_idx--;
                end else if (bitcnt == 9 && sh[7:6] == 2'b10) begin
                    reading = 1; raddr = sh[5:0]; rd_idx = 15; dout = 0;
                end
            end
            if (!cs && cs_p) begin
                if (bitcnt == 0) poll_cnt++;
                else finish_frame();
                reading = 0;
            end
            low_cnt = cs ? 0 : low_cnt + 1;
            cs_p = cs; sk_p = sk;
            do_r = !cs ? 1'b0 : (reading ? dout : (busy == 0));
        end
    end

    // Offer one request, wait for done, check the handshake (R9).
    task automatic issue(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d, input logic au);
        int n;
        nfrm = 0; poll_cnt = 0;
        @(negedge clk);
        req_valid = 1; req_cmd = c; req_addr = a; req_data = d; req_auto = au;
        n = 0;
        while (!req_ready && n < 1000) begin @(negedge clk); n++; end
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R9 ready low after accept", req_ready, 0);
        n = 0;
        while (!done_o && n < 20000) begin @(negedge clk); n++; end
        chk(done_o, "R9 done seen", done_o, 1);
        got_err = err_o; got_rd = rdata; got_cyc = n;
        @(negedge clk);
        chk(!done_o, "R9 done one cycle", done_o, 0);
    endtask

    task automatic t_reset();
        chk(!cs && !sk && !di, "R1 bus idle", {cs, sk, di}, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
        chk(!done_o && !err_o, "R1 done/err low", {done_o, err_o}, 0);
    endtask

    task automatic t_enable_write();
        issue(3'd5, 6'd0, 16'h0, 0);
        chk(nfrm == 1 && log_hdr[0] == 9'b100110000, "R2 enable frame", log_hdr[0], 9'b100110000);
        busy_len = 40;
        issue(3'd1, 6'd5, 16'hA5C3, 0);
        chk(log_len[0] == 25 && log_hdr[0] == 9'b101000101, "R2 write header", log_hdr[0], 9'b101000101);
        chk(log_dat[0] == 16'hA5C3, "R2 write data", log_dat[0], 16'hA5C3);
        chk(poll_cnt == 1 && !got_err, "R6 one poll phase, no error", poll_cnt, 1);
        chk(got_cyc > busy_len, "R6 done waits for ready", got_cyc, busy_len);
    endtask

    task automatic t_read();
        issue(3'd0, 6'd5, 16'h0, 0);
        chk(got_rd == 16'hA5C3, "R3 read word 5", got_rd, 16'hA5C3);
        chk(log_len[0] == 25 && log_hdr[0] == 9'b110000101, "R3 read frame", log_hdr[0], 9'b110000101);
        issue(3'd0, 6'd6, 16'h0, 0);
        chk(got_rd == 16'h8001, "R3 read edge bits", got_rd, 16'h8001);
        chk(poll_cnt == 0, "R6 no poll after read", poll_cnt, 0);
    endtask

    task automatic t_erase();
        issue(3'd2, 6'd5, 16'h0, 0);
        chk(log_len[0] == 9 && log_hdr[0] == 9'b111000101, "R2 erase frame", log_hdr[0], 9'b111000101);
        issue(3'd0, 6'd5, 16'h0, 0);
        chk(got_rd == 16'hFFFF, "R6 erased word", got_rd, 16'hFFFF);
    endtask

    task automatic t_all();
        issue(3'd4, 6'd0, 16'h1234, 0);
        chk(log_hdr[0][8:4] == 5'b10001 && log_dat[0] == 16'h1234, "R2 write-all frame", log_hdr[0], 9'b100010000);
        issue(3'd0, 6'd63, 16'h0, 0);
        chk(got_rd == 16'h1234, "R6 write-all word 63", got_rd, 16'h1234);
        issue(3'd3, 6'd0, 16'h0, 0);
        chk(log_len[0] == 9 && log_hdr[0][8:4] == 5'b10010, "R2 erase-all frame", log_hdr[0], 9'b100100000);
        issue(3'd0, 6'd17, 16'h0, 0);
        chk(got_rd == 16'hFFFF, "R6 erase-all word 17", got_rd, 16'hFFFF);
    endtask

    task automatic t_disable();
        issue(3'd6, 6'd0, 16'h0, 0);
        chk(log_hdr[0] == 9'b100000000, "R2 disable frame", log_hdr[0], 9'b100000000);
        issue(3'd1, 6'd3, 16'h0000, 0);
        chk(!got_err, "R6 rejected write still completes", got_err, 0);
        issue(3'd0, 6'd3, 16'h0, 0);
        chk(got_rd == 16'hFFFF, "R2 write after disable has no effect", got_rd, 16'hFFFF);
    endtask

    task automatic t_auto_en();
        issue(3'd1, 6'd9, 16'h5A5A, 1);
        chk(nfrm == 2 && log_hdr[0][8:4] == 5'b10011, "R8 enable frame first", log_hdr[0], 9'b100111001);
        chk(log_hdr[1] == 9'b101001001 && log_dat[1] == 16'h5A5A, "R8 command follows", log_hdr[1], 9'b101001001);
        issue(3'd0, 6'd9, 16'h0, 1);
        chk(nfrm == 1 && got_rd == 16'h5A5A, "R8 read ignores option", nfrm, 1);
    endtask

    task automatic t_timeout();
        busy_len = 1000;
        issue(3'd1, 6'd10, 16'h1111, 0);
        chk(got_err, "R7 timeout flagged", got_err, 1);
        chk(!cs, "R7 chip select dropped", cs, 0);
        while (busy > 0) @(negedge clk);
        busy_len = 20;
        issue(3'd1, 6'd11, 16'h2222, 0);
        chk(!got_err, "R7 no error on normal write", got_err, 0);
        issue(3'd0, 6'd11, 16'h0, 0);
        chk(got_rd == 16'h2222, "R6 write after timeout", got_rd, 16'h2222);
    endtask

    task automatic t_monitors();
        chk(sk_viol == 0, "R4 clock level width", sk_viol, 0);
        chk(gap_viol == 0, "R5 chip select gap", gap_viol, 0);
        chk(di_viol == 0, "R10 data low while deselected", di_viol, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i);
        mem[6] = 16'h8001;
        busy_len = 40;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_enable_write();
        t_read();
        t_erase();
        t_all();
        t_disable();
        t_auto_en();
        t_timeout();
        t_monitors();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule